// File: doc/BRIEF.md
# Tagged Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A fetch unit presents the branch address and its signed displacement on the lookup port. In the same cycle it receives a taken or not-taken guess and a flag that says whether the table held an entry for that address. When the branch resolves, the execute side reports the address and the real outcome on the update port, and the block trains its table on the next rising clock edge.

The table is direct-mapped with 512 slots. Each slot stores an address tag, a valid flag and a saturating four-level confidence counter. When the table has no matching entry, the sign of the displacement decides: a backward branch is guessed taken and a forward branch is guessed not taken. This fits loops, which branch backwards.

Top module: `branch_dir_predictor`

## Requirements
- R1: The table has 512 slots selected by pc[10:2], and pc[31:11] is kept as the tag. After reset every slot is empty, so every lookup reports lk_hit=0.
- R2: On a lookup with no matching entry, lk_taken equals the sign bit of lk_offset: 1 for a negative displacement, and 0 for a positive or zero one.
- R3: An update for an address with no matching entry fills the slot. The counter becomes weak-taken (code 2) if up_taken=1 and weak-not-taken (code 1) otherwise, and later lookups of that address report lk_hit=1.
- R4: An update that hits moves the counter one level. A taken outcome moves it toward strong-taken (code 3) and a not-taken outcome toward strong-not-taken (code 0), in the order 0,1,2,3.
- R5: The counter saturates. A taken update at strong-taken, or a not-taken update at strong-not-taken, leaves it unchanged.
- R6: On a hit, lk_taken is 1 exactly when the counter is weak-taken or strong-taken, whatever the displacement.
- R7: An address that shares a slot but has a different tag is a miss and uses the displacement rule. An update from that address replaces the slot, after which the old address misses.
- R8: The lookup is combinational. A lookup in the same cycle as an update of the same slot sees the state from before the update, and the new state is visible after the clock edge.
- R9: While up_valid=0 the table does not change, whatever up_pc and up_taken carry.
- R10: pc[1:0] takes no part in indexing or tag matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_offset | input | 16 | Signed branch displacement used on a miss |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hit | output | 1 | Table held a matching entry |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Lookup results are combinational, so the bench drives the lookup inputs just after a falling edge and samples a nanosecond later, within the same cycle. An update takes effect one rising edge after it is presented. The bench holds up_valid for exactly one cycle, drops it at the next falling edge and only then looks up the result, so each check reads the state after the edge. For the same-cycle case it samples both before and after that edge. Reset release passes through two synchronising flops, so the bench waits several cycles before it trains the table.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CNT_SNT = 2'b00,
    CNT_WNT = 2'b01,
    CNT_WT  = 2'b10,
    CNT_ST  = 2'b11
  } cnt_e;
endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bp_sat_ctr.sv
module bp_sat_ctr
  import bp_pkg::*;
(
  input  cnt_e cur,
  input  logic hit,
  input  logic taken,
  output cnt_e nxt
);
  always_comb begin
    nxt = cur;
    if (!hit) begin
      nxt = taken ? CNT_WT : CNT_WNT;
    end else if (taken) begin
      case (cur)
        CNT_SNT: nxt = CNT_WNT;
        CNT_WNT: nxt = CNT_WT;
        default: nxt = CNT_ST;
      endcase
    end else begin
      case (cur)
        CNT_ST:  nxt = CNT_WT;
        CNT_WT:  nxt = CNT_WNT;
        default: nxt = CNT_SNT;
      endcase
    end
  end
endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output cnt_e            rd_state,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LO      = 2;
  localparam int TAG_W   = PC_W - IDX_W - LO;

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  cnt_e               st_q  [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] vld_d;

  logic [IDX_W-1:0] ri, wi;
  logic [TAG_W-1:0] rt, wt;
  logic             wr_hit;
  cnt_e             wr_cur;
  cnt_e             wr_nxt;
  logic             unused_low;

  assign ri = rd_pc[IDX_W+LO-1:LO];
  assign rt = rd_pc[PC_W-1:IDX_W+LO];
  assign wi = wr_pc[IDX_W+LO-1:LO];
  assign wt = wr_pc[PC_W-1:IDX_W+LO];
  assign unused_low = ^{rd_pc[LO-1:0], wr_pc[LO-1:0]};

  assign rd_hit   = vld_q[ri] && (tag_q[ri] == rt);
  assign rd_state = st_q[ri];
  assign wr_hit   = vld_q[wi] && (tag_q[wi] == wt);
  assign wr_cur   = st_q[wi];

  bp_sat_ctr u_ctr (
    .cur   (wr_cur),
    .hit   (wr_hit),
    .taken (wr_taken),
    .nxt   (wr_nxt)
  );

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wi] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wi] <= wt;
      st_q[wi]  <= wr_nxt;
    end
  end

  // R3
  alloc_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> (vld_q[$past(wi)] &&
      (st_q[$past(wi)] == ($past(wr_taken) ? CNT_WT : CNT_WNT))));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && wr_taken && wr_cur != CNT_ST) |=>
      (2'(st_q[$past(wi)]) == 2'($past(wr_cur)) + 2'd1));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && !wr_taken && wr_cur != CNT_SNT) |=>
      (2'(st_q[$past(wi)]) == 2'($past(wr_cur)) - 2'd1));

  // R5
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && ((wr_taken && wr_cur == CNT_ST) ||
                         (!wr_taken && wr_cur == CNT_SNT))) |=>
      $stable(vld_q) && (st_q[$past(wi)] == $past(wr_cur)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 9,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [OFS_W-1:0] lk_offset,
  output logic             lk_taken,
  output logic             lk_hit,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic             up_taken
);
  logic rst_n_sync;
  logic tbl_hit;
  cnt_e tbl_state;
  logic static_taken;
  logic dyn_taken;

  bp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bp_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rd_pc    (lk_pc),
    .rd_hit   (tbl_hit),
    .rd_state (tbl_state),
    .wr_en    (up_valid),
    .wr_pc    (up_pc),
    .wr_taken (up_taken)
  );

  assign static_taken = lk_offset[OFS_W-1];
  assign dyn_taken    = (tbl_state == CNT_WT) || (tbl_state == CNT_ST);
  assign lk_hit       = tbl_hit;
  assign lk_taken     = tbl_hit ? dyn_taken : static_taken;

  // R2
  miss_static_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !lk_hit |-> (lk_taken == lk_offset[OFS_W-1]));
endmodule

// File: tb/test_branch_dir_predictor.sv
module test_branch_dir_predictor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic [15:0] lk_offset;
  logic        lk_taken, lk_hit;
  logic        up_valid;
  logic [31:0] up_pc;
  logic        up_taken;
  int checks = 0;
  int errors = 0;

  localparam logic [15:0] NEG = 16'hFFF0;
  localparam logic [15:0] POS = 16'h0020;

  always #10 clk = ~clk;

  branch_dir_predictor i_branch_dir_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_offset(lk_offset),
    .lk_taken(lk_taken), .lk_hit(lk_hit), .up_valid(up_valid),
    .up_pc(up_pc), .up_taken(up_taken)
  );

  task automatic look(input logic [31:0] pc, input logic [15:0] ofs,
                      input logic eh, input logic et, input string req);
    lk_pc = pc; lk_offset = ofs;
    #1;
    checks++;
    if (lk_hit !== eh || lk_taken !== et) begin
      errors++;
      $display("FAIL %s pc=%h hit/taken actual=%b%b expected=%b%b",
               req, pc, lk_hit, lk_taken, eh, et);
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_taken = tk;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset;
    look(32'h0000_1040, POS, 1'b0, 1'b0, "R1");
    look(32'hFFFF_FFFC, NEG, 1'b0, 1'b1, "R1");
  endtask

  task automatic t_static;
    look(32'h0000_2000, NEG, 1'b0, 1'b1, "R2");
    look(32'h0000_2000, POS, 1'b0, 1'b0, "R2");
    look(32'h0000_2000, 16'h0000, 1'b0, 1'b0, "R2");
    look(32'h0000_2000, 16'h8000, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_alloc;
    upd(32'h0000_3004, 1'b1);
    look(32'h0000_3004, POS, 1'b1, 1'b1, "R3");
    upd(32'h0000_3008, 1'b0);
    look(32'h0000_3008, NEG, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_train;
    logic [31:0] p = 32'h0000_4010;
    upd(p, 1'b1); look(p, POS, 1'b1, 1'b1, "R4 WT");
    upd(p, 1'b0); look(p, NEG, 1'b1, 1'b0, "R4 WNT");
    upd(p, 1'b0); look(p, NEG, 1'b1, 1'b0, "R4 SNT");
    upd(p, 1'b1); look(p, NEG, 1'b1, 1'b0, "R6 WNT");
    upd(p, 1'b1); look(p, POS, 1'b1, 1'b1, "R6 WT");
    upd(p, 1'b1); look(p, POS, 1'b1, 1'b1, "R4 ST");
    upd(p, 1'b0); look(p, NEG, 1'b1, 1'b1, "R4 ST->WT");
    upd(p, 1'b0); look(p, NEG, 1'b1, 1'b0, "R4 WT->WNT");
  endtask

  task automatic t_sat;
    logic [31:0] p = 32'h0000_5020;
    upd(p, 1'b1); upd(p, 1'b1); upd(p, 1'b1); upd(p, 1'b1);
    upd(p, 1'b0);
    look(p, POS, 1'b1, 1'b1, "R5 high");
    upd(p, 1'b0); upd(p, 1'b0); upd(p, 1'b0); upd(p, 1'b0);
    upd(p, 1'b1);
    look(p, NEG, 1'b1, 1'b0, "R5 low");
  endtask

  task automatic t_alias;
    upd(32'h0000_1040, 1'b1);
    look(32'h0000_1040, POS, 1'b1, 1'b1, "R7 base");
    look(32'h0000_1840, POS, 1'b0, 1'b0, "R7 alias miss");
    look(32'h0000_1840, NEG, 1'b0, 1'b1, "R7 alias miss");
    upd(32'h0000_1840, 1'b0);
    look(32'h0000_1840, POS, 1'b1, 1'b0, "R7 replaced");
    look(32'h0000_1040, POS, 1'b0, 1'b0, "R7 evicted");
  endtask

  task automatic t_bypass;
    logic [31:0] p = 32'h0000_6030;
    upd(p, 1'b0);
    @(negedge clk);
    up_valid = 1'b1; up_pc = p; up_taken = 1'b1;
    look(p, POS, 1'b1, 1'b0, "R8 old");
    @(negedge clk);
    up_valid = 1'b0;
    look(p, POS, 1'b1, 1'b1, "R8 new");
  endtask

  task automatic t_idle;
    logic [31:0] p = 32'h0000_7040;
    @(negedge clk);
    up_valid = 1'b0; up_pc = p; up_taken = 1'b1;
    repeat (3) @(negedge clk);
    look(p, POS, 1'b0, 1'b0, "R9 no alloc");
    upd(p, 1'b0);
    @(negedge clk);
    up_valid = 1'b0; up_pc = p; up_taken = 1'b1;
    repeat (3) @(negedge clk);
    look(p, POS, 1'b1, 1'b0, "R9 no step");
  endtask

  task automatic t_lowbits;
    upd(32'h0000_8003, 1'b1);
    look(32'h0000_8000, NEG, 1'b1, 1'b1, "R10");
    look(32'h0000_8001, POS, 1'b1, 1'b1, "R10");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
    lk_pc = '0; lk_offset = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_static;
    t_alloc;
    t_train;
    t_sat;
    t_alias;
    t_bypass;
    t_idle;
    t_lowbits;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule